// File: doc/BRIEF.md
# System Exception Pending Register

This block is one 32-bit control and status word for a small interrupt controller. It holds the pending state of three system exceptions:

- a non-maskable interrupt (exception number 2);
- a software-requested context-switch exception (number 14);
- a periodic-timer exception (number 15).

Software changes that state through a simple register write port. A write uses write-one-to-set and write-one-to-clear bits, and a written 0 never changes anything. Hardware can also raise the non-maskable and timer exceptions directly. The core clears a pending flag by sending a one-cycle handler-entry pulse that carries the exception number it is entering.

The read word is combinational and always present. It carries:

- the three pending flags;
- a summary flag that is 1 when any interrupt other than the non-maskable one is pending;
- the number of the highest-priority pending enabled exception;
- the active exception number, which the core supplies.

External lines number from 16 upward, so line `i` is exception `16+i`. The per-exception priorities come in as inputs. The block only compares them.

All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `exc_pend_ctrl`

## Requirements
- R1: After reset all three pending flags are 0. With no external line pending and `active_num` at 0, the read word is 0.
- R2: Writing 1 to bit 31, or pulsing `nmi_raise`, makes the non-maskable exception pending from the next cycle. Bit 31 of the read word shows that pending state.
- R3: Writing 1 to bit 28 makes the context-switch exception pending. Writing 1 to bit 27 clears it. Bit 28 reads back the state. A bus write of bit 28 is the only way to set this flag.
- R4: Writing 1 to bit 26, or pulsing `tick_raise`, makes the timer exception pending. Writing 1 to bit 25 clears it. Bit 26 reads back the state.
- R5: When one write carries both the set bit and the clear bit of the same exception, the flag ends up cleared.
- R6: A handler-entry pulse whose number is 2, 14 or 15 clears the matching flag in the cycle it is taken. If a set of that same flag arrives in the same cycle, the flag stays pending.
- R7: Read bit 22 is 1 exactly when the context-switch flag, the timer flag, or any bit of `irq_pend` is set, whether or not that line is enabled.
- R8: Read bits [17:12] report which exception wins:
  - 2 whenever the non-maskable flag is set;
  - otherwise the number of the pending candidate with the numerically lowest priority value, with ties going to the lower number;
  - 0 when nothing is pending.
  The candidates are the context-switch flag, the timer flag, and each external line whose pending and enable bits are both set.
- R9: Read bits [5:0] equal `active_num`.
- R10: Writing 0 to any bit has no effect. Bits 30:29, 27, 25, 24:23, 21:18 and 11:6 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 32 | Write data with the set and clear bits |
| rd_data | output | 32 | Current register value (combinational) |
| nmi_raise | input | 1 | Hardware request to pend the non-maskable exception |
| tick_raise | input | 1 | Hardware request to pend the timer exception |
| entry_valid | input | 1 | Handler-entry pulse |
| entry_num | input | 6 | Exception number being entered |
| active_num | input | 6 | Number of the currently active exception, 0 in thread mode |
| csw_prio | input | PRIO_W | Priority of the context-switch exception |
| tmr_prio | input | PRIO_W | Priority of the timer exception |
| irq_pend | input | NIRQ | Pending state of the external lines |
| irq_en | input | NIRQ | Enable state of the external lines |
| irq_prio_flat | input | NIRQ*PRIO_W | Priorities of the external lines, line i at bits [i*PRIO_W +: PRIO_W] |

## Verification
The assertions assume three things about the inputs:

- `entry_valid` is a single-cycle pulse;
- `entry_num` is only meaningful while `entry_valid` is high;
- the priority and external-line inputs are settled before the read word is sampled.

The bench drives every input on the falling edge and holds handler-entry pulses to exactly one cycle. It sweeps every combination of prior state, set bit, clear bit and entry pulse for both software-clearable flags. It then walks 256 patterns of external pending bits, enable bits and priorities under each of the four flag states, so the arbitration checks always see settled inputs.

// File: rtl/exc_pend_pkg.sv
package exc_pend_pkg;
  localparam int NUM_W = 6;
  localparam int NFLAG = 3;

  // flag indices
  localparam int F_NMI = 0;
  localparam int F_CSW = 1;
  localparam int F_TMR = 2;

  // exception numbers
  localparam logic [NUM_W-1:0] EXC_NMI = 6'd2;
  localparam logic [NUM_W-1:0] EXC_CSW = 6'd14;
  localparam logic [NUM_W-1:0] EXC_TMR = 6'd15;
  localparam int IRQ_BASE = 16;

  // register bit positions
  localparam int B_NMI_SET = 31;
  localparam int B_CSW_SET = 28;
  localparam int B_CSW_CLR = 27;
  localparam int B_TMR_SET = 26;
  localparam int B_TMR_CLR = 25;
  localparam int B_ANY     = 22;
  localparam int B_VECT_LO = 12;
  localparam int B_ACT_LO  = 0;
endpackage

// File: rtl/exc_pend_flags.sv
module exc_pend_flags
  import exc_pend_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_req,
  input  logic [NFLAG-1:0] clr_req,
  input  logic             entry_valid,
  input  logic [NUM_W-1:0] entry_num,
  output logic [NFLAG-1:0] pend
);
  logic [NUM_W-1:0] flag_num [NFLAG];
  assign flag_num[F_NMI] = EXC_NMI;
  assign flag_num[F_CSW] = EXC_CSW;
  assign flag_num[F_TMR] = EXC_TMR;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    logic ent_hit;
    assign ent_hit = entry_valid && (entry_num == flag_num[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pend[i] <= 1'b0;
      else if (clr_req[i]) pend[i] <= 1'b0;   // clear beats set
      else if (set_req[i]) pend[i] <= 1'b1;   // set beats handler entry
      else if (ent_hit)    pend[i] <= 1'b0;
    end
  end

  // R5: clear wins over set for the same flag
  a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req[F_CSW] && clr_req[F_CSW]) |=> !pend[F_CSW]);
  // R3: the context-switch flag rises only after a set request
  a_r3_only_set: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[F_CSW]) |-> $past(set_req[F_CSW]));
  // R2: a set of the non-maskable flag always lands
  a_r2_nmi_set: assert property (@(posedge clk) disable iff (!rst_n)
    set_req[F_NMI] |=> pend[F_NMI]);
  // R6: handler entry clears the timer flag unless it is set that cycle
  a_r6_entry_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_valid && entry_num == EXC_TMR && !set_req[F_TMR]) |=> !pend[F_TMR]);
  // R6: a set in the entry cycle keeps the flag pending
  a_r6_set_beats_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_valid && entry_num == EXC_CSW && set_req[F_CSW] && !clr_req[F_CSW])
      |=> pend[F_CSW]);
endmodule

// File: rtl/exc_pend_arb.sv
module exc_pend_arb
  import exc_pend_pkg::*;
#(
  parameter int NIRQ   = 4,
  parameter int PRIO_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NFLAG-1:0]       pend,
  input  logic [PRIO_W-1:0]      csw_prio,
  input  logic [PRIO_W-1:0]      tmr_prio,
  input  logic [NIRQ-1:0]        irq_pend,
  input  logic [NIRQ-1:0]        irq_en,
  input  logic [NIRQ*PRIO_W-1:0] irq_prio_flat,
  output logic [NUM_W-1:0]       vect_pend,
  output logic                   any_pend
);
  localparam int NCAND = NIRQ + 2;

  logic              cand_vld  [NCAND];
  logic [PRIO_W-1:0] cand_prio [NCAND];
  logic [NUM_W-1:0]  cand_num  [NCAND];

  // candidates listed in ascending exception number
  assign cand_vld[0]  = pend[F_CSW];
  assign cand_prio[0] = csw_prio;
  assign cand_num[0]  = EXC_CSW;
  assign cand_vld[1]  = pend[F_TMR];
  assign cand_prio[1] = tmr_prio;
  assign cand_num[1]  = EXC_TMR;

  for (genvar i = 0; i < NIRQ; i++) begin : g_irq
    assign cand_vld[i+2]  = irq_pend[i] && irq_en[i];
    assign cand_prio[i+2] = irq_prio_flat[i*PRIO_W +: PRIO_W];
    assign cand_num[i+2]  = NUM_W'(IRQ_BASE + i);
  end

  logic              best_vld;
  logic [PRIO_W-1:0] best_prio;
  logic [NUM_W-1:0]  best_num;

  always_comb begin
    best_vld  = 1'b0;
    best_prio = '0;
    best_num  = '0;
    for (int j = 0; j < NCAND; j++) begin
      // strict compare: on a tie the earlier (lower) number stays
      if (cand_vld[j] && (!best_vld || cand_prio[j] < best_prio)) begin
        best_vld  = 1'b1;
        best_prio = cand_prio[j];
        best_num  = cand_num[j];
      end
    end
  end

  assign vect_pend = pend[F_NMI] ? EXC_NMI : best_num;
  assign any_pend  = pend[F_CSW] | pend[F_TMR] | (|irq_pend);

  // R8: the non-maskable exception always wins
  a_r8_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
    pend[F_NMI] |-> vect_pend == EXC_NMI);
  // R8: nothing pending reports zero
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0 && (irq_pend & irq_en) == '0) |-> vect_pend == '0);
  // R7: a pending software flag raises the summary bit
  a_r7_summary: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[F_CSW] || pend[F_TMR]) |-> any_pend);
endmodule

// File: rtl/exc_pend_ctrl.sv
module exc_pend_ctrl
  import exc_pend_pkg::*;
#(
  parameter int NIRQ   = 4,
  parameter int PRIO_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [31:0]            wr_data,
  output logic [31:0]            rd_data,
  input  logic                   nmi_raise,
  input  logic                   tick_raise,
  input  logic                   entry_valid,
  input  logic [NUM_W-1:0]       entry_num,
  input  logic [NUM_W-1:0]       active_num,
  input  logic [PRIO_W-1:0]      csw_prio,
  input  logic [PRIO_W-1:0]      tmr_prio,
  input  logic [NIRQ-1:0]        irq_pend,
  input  logic [NIRQ-1:0]        irq_en,
  input  logic [NIRQ*PRIO_W-1:0] irq_prio_flat
);
  logic [NFLAG-1:0] set_req, clr_req, pend;
  logic [NUM_W-1:0] vect_pend;
  logic             any_pend;
  logic             unused_wr_bits;

  assign set_req[F_NMI] = (wr_en && wr_data[B_NMI_SET]) || nmi_raise;
  assign set_req[F_CSW] =  wr_en && wr_data[B_CSW_SET];
  assign set_req[F_TMR] = (wr_en && wr_data[B_TMR_SET]) || tick_raise;
  assign clr_req[F_NMI] = 1'b0;
  assign clr_req[F_CSW] =  wr_en && wr_data[B_CSW_CLR];
  assign clr_req[F_TMR] =  wr_en && wr_data[B_TMR_CLR];
  assign unused_wr_bits = ^{wr_data[30:29], wr_data[24:0]};

  exc_pend_flags u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_req     (set_req),
    .clr_req     (clr_req),
    .entry_valid (entry_valid),
    .entry_num   (entry_num),
    .pend        (pend)
  );

  exc_pend_arb #(.NIRQ(NIRQ), .PRIO_W(PRIO_W)) u_arb (
    .clk           (clk),
    .rst_n         (rst_n),
    .pend          (pend),
    .csw_prio      (csw_prio),
    .tmr_prio      (tmr_prio),
    .irq_pend      (irq_pend),
    .irq_en        (irq_en),
    .irq_prio_flat (irq_prio_flat),
    .vect_pend     (vect_pend),
    .any_pend      (any_pend)
  );

  always_comb begin
    rd_data                              = '0;
    rd_data[B_NMI_SET]                   = pend[F_NMI];
    rd_data[B_CSW_SET]                   = pend[F_CSW];
    rd_data[B_TMR_SET]                   = pend[F_TMR];
    rd_data[B_ANY]                       = any_pend;
    rd_data[B_VECT_LO +: NUM_W]          = vect_pend;
    rd_data[B_ACT_LO +: NUM_W]           = active_num;
  end

  // R10: write-only and reserved positions never read back as 1
  a_r10_quiet_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & 32'h6BBC_0FC0) == 32'h0);
  // R3: a write of 1 to the context-switch set bit alone makes it pending
  a_r3_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[B_CSW_SET] && !wr_data[B_CSW_CLR]) |=> rd_data[B_CSW_SET]);
endmodule

// File: tb/tb_exc_pend_ctrl.sv
module tb_exc_pend_ctrl;
  localparam int NIRQ = 4;
  localparam int PW   = 2;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic nmi_raise = 0, tick_raise = 0, entry_valid = 0;
  logic [5:0] entry_num = '0, active_num = '0;
  logic [PW-1:0] csw_prio = '0, tmr_prio = '0;
  logic [NIRQ-1:0] irq_pend = '0, irq_en = '0;
  logic [NIRQ*PW-1:0] irq_prio_flat = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;   // 250 MHz

  exc_pend_ctrl #(.NIRQ(NIRQ), .PRIO_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .nmi_raise(nmi_raise), .tick_raise(tick_raise), .entry_valid(entry_valid),
    .entry_num(entry_num), .active_num(active_num), .csw_prio(csw_prio),
    .tmr_prio(tmr_prio), .irq_pend(irq_pend), .irq_en(irq_en),
    .irq_prio_flat(irq_prio_flat)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  // one clock of stimulus, launched on a falling edge, result visible at the next one
  task automatic cyc(input logic w, input logic [31:0] d, input logic nr, input logic tr,
                     input logic ev, input logic [5:0] en);
    @(negedge clk);
    wr_en = w; wr_data = d; nmi_raise = nr; tick_raise = tr;
    entry_valid = ev; entry_num = en;
    @(negedge clk);
    wr_en = 0; wr_data = '0; nmi_raise = 0; tick_raise = 0; entry_valid = 0; entry_num = '0;
    #0;
  endtask

  // R8 reference: minimum of prio*64+number over candidates
  function automatic logic [5:0] ref_vect(input logic n, input logic c, input logic t,
      input logic [PW-1:0] cp, input logic [PW-1:0] tp, input logic [NIRQ-1:0] ip,
      input logic [NIRQ-1:0] ie, input logic [NIRQ*PW-1:0] pr);
    int best = 1 << 20;
    if (n) return 6'd2;
    if (c && (cp * 64 + 14) < best) best = cp * 64 + 14;
    if (t && (tp * 64 + 15) < best) best = tp * 64 + 15;
    for (int i = 0; i < NIRQ; i++)
      if (ip[i] && ie[i] && (pr[i*PW +: PW] * 64 + 16 + i) < best)
        best = pr[i*PW +: PW] * 64 + 16 + i;
    return (best == (1 << 20)) ? 6'd0 : 6'(best % 64);
  endfunction

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset word", rd_data, 32'h0);
    active_num = 6'd37; #1;
    chk("R9 active field", rd_data, 32'd37);
    active_num = 6'd0;

    // R2 non-maskable flag
    cyc(1, 32'h8000_0000, 0, 0, 0, 0);
    chk("R2 set by write", rd_data, 32'h8000_2000);
    cyc(1, 32'h0, 0, 0, 0, 0);
    chk("R10 zero write no effect", rd_data, 32'h8000_2000);
    cyc(0, 0, 0, 0, 1, 6'd2);
    chk("R6 entry clears nmi", rd_data, 32'h0);
    cyc(0, 0, 1, 0, 0, 0);
    chk("R2 set by raise", rd_data[31], 32'h1);
    cyc(0, 0, 1, 0, 1, 6'd2);
    chk("R6 raise beats entry", rd_data[31], 32'h1);
    cyc(0, 0, 0, 0, 1, 6'd14);
    chk("R6 other entry ignored", rd_data[31], 32'h1);
    cyc(0, 0, 0, 0, 1, 6'd2);
    chk("R6 entry clears nmi again", rd_data, 32'h0);

    // R3 only a bus write sets the context-switch flag
    cyc(0, 0, 1, 1, 1, 6'd14);
    chk("R3 no hardware set", rd_data[28], 32'h0);
    chk("R4 set by tick_raise", rd_data[26], 32'h1);
    cyc(1, 32'h0200_0000, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 6'd2);

    // R3 R4 R5 R6 sweep over both software-clearable flags
    for (int f = 0; f < 2; f++) begin
      for (int v = 0; v < 16; v++) begin
        logic init, s, c, e, expv;
        int sb, cb;
        logic [5:0] num;
        init = v[0]; s = v[1]; c = v[2]; e = v[3];
        sb = f ? 26 : 28; cb = f ? 25 : 27; num = f ? 6'd15 : 6'd14;
        cyc(1, 32'(1) << (init ? sb : cb), 0, 0, 0, 0);
        cyc(1, (32'(s) << sb) | (32'(c) << cb), 0, 0, e, num);
        expv = c ? 1'b0 : (s ? 1'b1 : (e ? 1'b0 : init));
        chk(f ? "R4 R5 R6 timer sweep" : "R3 R5 R6 switch sweep", rd_data[sb], 32'(expv));
        chk("R10 quiet bits", rd_data & 32'h6BBC_0FC0, 32'h0);
      end
    end

    // R7 R8 sweep
    for (int st = 0; st < 4; st++) begin
      cyc(1, (st[0] ? 32'h1000_0000 : 32'h0800_0000) | (st[1] ? 32'h0400_0000 : 32'h0200_0000),
          0, 0, 0, 0);
      for (int k = 0; k < 256; k++) begin
        logic [7:0] pr;
        pr = 8'((k * 53 + st * 7) % 256);
        @(negedge clk);
        irq_pend = k[3:0]; irq_en = ~k[7:4]; irq_prio_flat = pr;
        csw_prio = 2'(k % 4); tmr_prio = 2'((k / 4) % 4);
        #1;
        chk("R7 summary bit", rd_data[22], 32'(st[0] | st[1] | (|k[3:0])));
        chk("R8 winner", rd_data[17:12],
            32'(ref_vect(0, st[0], st[1], 2'(k % 4), 2'((k / 4) % 4), k[3:0], ~k[7:4], pr)));
      end
    end
    cyc(1, 32'h8000_0000, 0, 0, 0, 0);
    chk("R8 nmi outranks all", rd_data[17:12], 32'd2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule